// File: doc/BRIEF.md
# Tag-array maintenance engine

This block walks a range of line addresses and applies one maintenance action to the tag store of a 4-way set-associative cache. A command carries an operation code, a start byte address and a count of lines. For each line the engine reads all ways of the indexed set in one access and compares each way's valid bit and tag field with the line's tag. It then rewrites the first matching entry. A write-back command also hands each dirty matching line to a write-out agent and waits for that agent to accept it before the dirty flag is cleared.

A sweep command clears the valid flag of every entry in the store, whatever address comes with it. A range that starts below the cache's address window, runs past its end or has zero length completes without touching the store. The engine serves one command at a time. `cmd_busy` is high from the cycle after acceptance through the one-cycle `cmd_done` pulse.

The controller has these states. `ST_IDLE` goes to `ST_CHECK` on `cmd_valid`. `ST_CHECK` goes to `ST_SWREAD` for a sweep, to `ST_DONE` for a reserved code or a rejected range, and to `ST_READ` otherwise. `ST_READ` goes to `ST_MATCH`. `ST_MATCH` goes to `ST_STEP` on a miss, to `ST_WBWAIT` on a dirty hit under write-back, and to `ST_WRITE` on any other hit. `ST_WBWAIT` goes to `ST_WRITE` on `wb_ack`. `ST_WRITE` goes to `ST_STEP`. `ST_STEP` goes to `ST_DONE` after the last line and back to `ST_READ` otherwise. `ST_SWREAD` goes to `ST_SWWRITE`. `ST_SWWRITE` goes to `ST_DONE` after the last set and back to `ST_SWREAD` otherwise. `ST_DONE` returns to `ST_IDLE`.

Top module: `tagm_engine`

## Requirements
- R1: After reset, `cmd_busy`, `cmd_done`, `tr_rd_en`, `tr_wr_en` and `wb_req` are all low, and none of the three request outputs is raised while the engine is not busy.
- R2: A command is taken only when `cmd_busy` is low. `cmd_busy` is high one cycle after `cmd_valid` is seen. Any `cmd_valid` that arrives while busy is ignored and leaves the store untouched.
- R3: The engine reads an entry as 32 bits, counting from bit 0 upward: dirty in bit 0, tag in bits 14:1, valid in bit 15, age in bits 18:16, lock in bit 19, attribute in bits 22:20, access in bit 23 and reserved bits in 31:24. For a line at offset `o` from the window base, the set is `o[10:4]` and the tag is `o[21:11]`. A way hits when it is valid and its tag matches. When several ways hit, only the lowest-numbered one is updated. Fields that the operation does not name keep their values.
- R4: Operation code 0 (invalidate) clears the valid bit of the hit entry.
- R5: Operation code 1 (clean) clears only the dirty bit of the hit entry.
- R6: Operation code 2 (write back) raises `wb_req` for each dirty hit, with the line address and the way. The request is held until `wb_ack`, and the dirty bit is cleared afterwards. A clean hit raises no request.
- R7: Operation code 3 (lock) sets bit 19 of the hit entry. Operation code 4 (unlock) clears it.
- R8: The start address is rounded down to a 16-byte line. The command covers that many consecutive lines and leaves lines outside the range unchanged.
- R9: A range with zero lines, a start below the window base, or an end above base plus 4 MiB completes with no write to the store.
- R10: Operation code 5 clears the valid bit of every entry in all 128 sets and keeps all other bits.
- R11: `cmd_done` is a single-cycle pulse that occurs while `cmd_busy` is high. `cmd_busy` is low in the following cycle.
- R12: Operation codes 6 and 7 complete with no write to the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken while idle |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 32 | Start byte address |
| cmd_lines | input | 16 | Number of lines |
| cmd_busy | output | 1 | Command in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| tr_rd_en | output | 1 | Tag store read strobe; data is returned one cycle later |
| tr_rd_set | output | 7 | Set to read |
| tr_rd_data | input | 128 | All four way entries of the set, with way 0 in the low bits |
| tr_wr_en | output | 1 | Tag store write strobe |
| tr_wr_set | output | 7 | Set to write |
| tr_wr_mask | output | 4 | Ways written |
| tr_wr_data | output | 128 | Entry data for each way lane |
| wb_req | output | 1 | Write-out request for a dirty line |
| wb_addr | output | 32 | Line-aligned address to write out |
| wb_way | output | 2 | Way holding the line |
| wb_ack | input | 1 | Write-out request accepted |

## Verification
The main stimulus is random tag contents drawn from a small pool of tags with mixed valid and dirty flags, run against random commands over the low part of the window, so hits, misses, duplicate-tag sets and dirty lines all occur often. A directed set holding the same tag in two ways separates lowest-way priority from any other choice. An unaligned start address separates rounding down from rounding up. Ranges just below the base, straddling the window's upper end and of zero length separate the rejection rule from clipping of the range. Reserved codes and a command injected while busy show that nothing is written, and random acknowledge delays on write-out expose a request that drops before it is accepted.

// File: rtl/tagm_pkg.sv
package tagm_pkg;

    localparam int ENTRY_W   = 32;
    localparam int TAG_FW    = 14;
    localparam int VALID_BIT = 15;

    typedef enum logic [2:0] {
        OP_INVAL  = 3'd0,
        OP_CLEAN  = 3'd1,
        OP_WBACK  = 3'd2,
        OP_LOCK   = 3'd3,
        OP_UNLOCK = 3'd4,
        OP_INVALL = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } maint_op_e;

    // bit 0 is the last member
    typedef struct packed {
        logic [7:0]        rsvd;
        logic              acc;
        logic [2:0]        attr;
        logic              lock;
        logic [2:0]        age;
        logic              valid;
        logic [TAG_FW-1:0] tag;
        logic              dirty;
    } tag_entry_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ,
        ST_MATCH,
        ST_WBWAIT,
        ST_WRITE,
        ST_STEP,
        ST_SWREAD,
        ST_SWWRITE,
        ST_DONE
    } eng_state_e;

endpackage

// File: rtl/tagm_range.sv
module tagm_range #(
    parameter int ADDR_W = 32,
    parameter int CNT_W = 16,
    parameter int OFS_W = 4,
    parameter int SET_W = 7,
    parameter int WIN_W = 22,
    parameter int TAG_USED = 11,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h3C00_0000,
    parameter int unsigned WIN_BYTES = 32'h0040_0000
) (
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [CNT_W-1:0]          req_lines,
    input  logic [ADDR_W-OFS_W-1:0]   line_idx,
    output logic                      range_ok,
    output logic                      line_ok,
    output logic [SET_W-1:0]          line_set,
    output logic [tagm_pkg::TAG_FW-1:0] line_tag
);
    localparam int CW = ADDR_W + CNT_W + 2;
    localparam int LW = ADDR_W - OFS_W;

    logic [CW-1:0] base_w, lim_w, start_w, span_w;
    logic [LW-1:0] ofs;

    always_comb begin
        base_w   = CW'(WIN_BASE);
        lim_w    = base_w + CW'(WIN_BYTES);
        start_w  = CW'(req_addr & ~ADDR_W'(2 ** OFS_W - 1));
        span_w   = CW'(req_lines) << OFS_W;
        range_ok = (req_lines != '0) && (start_w >= base_w)
                   && ((start_w + span_w) <= lim_w);
    end

    always_comb begin
        ofs      = line_idx - LW'(WIN_BASE >> OFS_W);
        line_ok  = ((ofs >> (WIN_W - OFS_W)) == '0);
        line_set = ofs[SET_W-1:0];
        line_tag = tagm_pkg::TAG_FW'(ofs[SET_W +: TAG_USED]);
    end

endmodule

// File: rtl/tagm_way_match.sv
module tagm_way_match
    import tagm_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS*ENTRY_W-1:0] set_data,
    input  logic [TAG_FW-1:0]       look_tag,
    output logic                    hit,
    output logic [WAY_W-1:0]        hit_way,
    output tag_entry_t              hit_entry
);
    tag_entry_t        ent [WAYS];
    logic [WAYS-1:0]   match;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign ent[w]   = tag_entry_t'(set_data[w*ENTRY_W +: ENTRY_W]);
        assign match[w] = ent[w].valid && (ent[w].tag == look_tag);
    end

    // lowest way wins
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
        hit       = |match;
        hit_entry = ent[hit_way];
    end

endmodule

// File: rtl/tagm_entry_update.sv
module tagm_entry_update
    import tagm_pkg::*;
(
    input  maint_op_e  op,
    input  tag_entry_t cur,
    output tag_entry_t nxt
);
    always_comb begin
        nxt = cur;
        unique case (op)
            OP_INVAL:            nxt.valid = 1'b0;
            OP_CLEAN, OP_WBACK:  nxt.dirty = 1'b0;
            OP_LOCK:             nxt.lock  = 1'b1;
            OP_UNLOCK:           nxt.lock  = 1'b0;
            default:             nxt = cur;
        endcase
    end

endmodule

// File: rtl/tagm_engine.sv
module tagm_engine
    import tagm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W = 16,
    parameter int WAYS = 4,
    parameter int LINE_BYTES = 16,
    parameter int CACHE_BYTES = 8192,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h3C00_0000,
    parameter int unsigned WIN_BYTES = 32'h0040_0000,
    localparam int OFS_W = $clog2(LINE_BYTES),
    localparam int SETS = CACHE_BYTES / (WAYS * LINE_BYTES),
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int DW = WAYS * ENTRY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_lines,
    output logic              cmd_busy,
    output logic              cmd_done,
    output logic              tr_rd_en,
    output logic [SET_W-1:0]  tr_rd_set,
    input  logic [DW-1:0]     tr_rd_data,
    output logic              tr_wr_en,
    output logic [SET_W-1:0]  tr_wr_set,
    output logic [WAYS-1:0]   tr_wr_mask,
    output logic [DW-1:0]     tr_wr_data,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [WAY_W-1:0]  wb_way,
    input  logic              wb_ack
);
    localparam int WIN_W    = $clog2(WIN_BYTES);
    localparam int LW       = ADDR_W - OFS_W;
    localparam int TAG_USED = WIN_W - OFS_W - SET_W;

    eng_state_e        state, state_d;
    maint_op_e         op_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [CNT_W-1:0]  left_q;
    logic [LW-1:0]     cur_line;
    logic [SET_W-1:0]  sw_set;
    logic [WAY_W-1:0]  hit_way_q;
    tag_entry_t        hit_ent_q;

    logic              range_ok, line_ok, hit;
    logic [SET_W-1:0]  line_set;
    logic [TAG_FW-1:0] line_tag;
    logic [WAY_W-1:0]  hit_way;
    tag_entry_t        hit_entry, nxt_entry;
    logic [ENTRY_W-1:0] nxt_bits;
    logic [DW-1:0]     sweep_data;

    tagm_range #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFS_W(OFS_W), .SET_W(SET_W),
        .WIN_W(WIN_W), .TAG_USED(TAG_USED),
        .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)
    ) u_range (
        .req_addr (req_addr_q),
        .req_lines(left_q),
        .line_idx (cur_line),
        .range_ok (range_ok),
        .line_ok  (line_ok),
        .line_set (line_set),
        .line_tag (line_tag)
    );

    tagm_way_match #(.WAYS(WAYS), .WAY_W(WAY_W)) u_match (
        .set_data (tr_rd_data),
        .look_tag (line_tag),
        .hit      (hit),
        .hit_way  (hit_way),
        .hit_entry(hit_entry)
    );

    tagm_entry_update u_update (
        .op (op_q),
        .cur(hit_ent_q),
        .nxt(nxt_entry)
    );

    assign nxt_bits = nxt_entry;

    for (genvar w = 0; w < WAYS; w++) begin : g_sweep
        assign sweep_data[w*ENTRY_W +: ENTRY_W] =
            tr_rd_data[w*ENTRY_W +: ENTRY_W] & ~(ENTRY_W'(1) << VALID_BIT);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:    if (cmd_valid) state_d = ST_CHECK;
            ST_CHECK: begin
                if (op_q == OP_INVALL)
                    state_d = ST_SWREAD;
                else if (op_q == OP_RSV6 || op_q == OP_RSV7 || !range_ok)
                    state_d = ST_DONE;
                else
                    state_d = ST_READ;
            end
            ST_READ:    state_d = ST_MATCH;
            ST_MATCH: begin
                if (!hit || !line_ok)
                    state_d = ST_STEP;
                else if (op_q == OP_WBACK && hit_entry.dirty)
                    state_d = ST_WBWAIT;
                else
                    state_d = ST_WRITE;
            end
            ST_WBWAIT:  if (wb_ack) state_d = ST_WRITE;
            ST_WRITE:   state_d = ST_STEP;
            ST_STEP:    state_d = (left_q == CNT_W'(1)) ? ST_DONE : ST_READ;
            ST_SWREAD:  state_d = ST_SWWRITE;
            ST_SWWRITE: state_d = (sw_set == SET_W'(SETS - 1)) ? ST_DONE : ST_SWREAD;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // command and walk registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_INVAL;
            req_addr_q <= '0;
            left_q     <= '0;
            cur_line   <= '0;
            sw_set     <= '0;
            hit_way_q  <= '0;
            hit_ent_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        op_q       <= maint_op_e'(cmd_op);
                        req_addr_q <= cmd_addr;
                        left_q     <= cmd_lines;
                        cur_line   <= cmd_addr[ADDR_W-1:OFS_W];
                        sw_set     <= '0;
                    end
                end
                ST_MATCH: begin
                    hit_way_q <= hit_way;
                    hit_ent_q <= hit_entry;
                end
                ST_STEP: begin
                    left_q   <= left_q - CNT_W'(1);
                    cur_line <= cur_line + LW'(1);
                end
                ST_SWWRITE: sw_set <= sw_set + SET_W'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_busy   = (state != ST_IDLE);
        cmd_done   = 1'b0;
        tr_rd_en   = 1'b0;
        tr_rd_set  = line_set;
        tr_wr_en   = 1'b0;
        tr_wr_set  = line_set;
        tr_wr_mask = '0;
        tr_wr_data = {WAYS{nxt_bits}};
        wb_req     = 1'b0;
        wb_addr    = {cur_line, {OFS_W{1'b0}}};
        wb_way     = hit_way_q;
        unique case (state)
            ST_READ:   tr_rd_en = 1'b1;
            ST_WBWAIT: wb_req = 1'b1;
            ST_WRITE: begin
                tr_wr_en   = 1'b1;
                tr_wr_mask = WAYS'(1) << hit_way_q;
            end
            ST_SWREAD: begin
                tr_rd_en  = 1'b1;
                tr_rd_set = sw_set;
            end
            ST_SWWRITE: begin
                tr_wr_en   = 1'b1;
                tr_wr_set  = sw_set;
                tr_wr_mask = '1;
                tr_wr_data = sweep_data;
            end
            ST_DONE:   cmd_done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/tagm_checker.sv
module tagm_checker #(
    parameter int ADDR_W = 32,
    parameter int WAYS = 4,
    parameter int WAY_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_busy,
    input logic              cmd_done,
    input logic              tr_rd_en,
    input logic              tr_wr_en,
    input logic [WAYS-1:0]   tr_wr_mask,
    input logic              wb_req,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [WAY_W-1:0]  wb_way,
    input logic              wb_ack
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_busy |-> (!tr_rd_en && !tr_wr_en && !wb_req));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_busy && cmd_valid) |=> cmd_busy);

    p_port_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tr_wr_en |-> (!tr_rd_en && tr_wr_mask != '0));

    p_wb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr) && $stable(wb_way)));

    p_wb_then_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && wb_ack) |=> (tr_wr_en && $countones(tr_wr_mask) == 1));

    p_done_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> cmd_busy);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> (!cmd_done && !cmd_busy));

endmodule

bind tagm_engine tagm_checker #(
    .ADDR_W(ADDR_W), .WAYS(WAYS), .WAY_W($clog2(WAYS))
) u_tagm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_busy  (cmd_busy),
    .cmd_done  (cmd_done),
    .tr_rd_en  (tr_rd_en),
    .tr_wr_en  (tr_wr_en),
    .tr_wr_mask(tr_wr_mask),
    .wb_req    (wb_req),
    .wb_addr   (wb_addr),
    .wb_way    (wb_way),
    .wb_ack    (wb_ack)
);

// File: tb/tagm_engine_bench.sv
module tagm_engine_bench;
    localparam int NS = 128;
    localparam int NW = 4;
    localparam logic [31:0] BASE = 32'h3C00_0000;
    localparam longint WINB = 64'h0040_0000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n, cmd_valid, cmd_busy, cmd_done;
    logic [2:0]   cmd_op;
    logic [31:0]  cmd_addr;
    logic [15:0]  cmd_lines;
    logic         tr_rd_en, tr_wr_en, wb_req;
    logic         wb_ack = 1'b0;
    logic [6:0]   tr_rd_set, tr_wr_set;
    logic [127:0] tr_rd_data = '0;
    logic [127:0] tr_wr_data;
    logic [3:0]   tr_wr_mask;
    logic [31:0]  wb_addr;
    logic [1:0]   wb_way;

    tagm_engine u_tagm_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_lines(cmd_lines), .cmd_busy(cmd_busy),
        .cmd_done(cmd_done), .tr_rd_en(tr_rd_en), .tr_rd_set(tr_rd_set),
        .tr_rd_data(tr_rd_data), .tr_wr_en(tr_wr_en), .tr_wr_set(tr_wr_set),
        .tr_wr_mask(tr_wr_mask), .tr_wr_data(tr_wr_data), .wb_req(wb_req),
        .wb_addr(wb_addr), .wb_way(wb_way), .wb_ack(wb_ack)
    );

    logic [31:0] mem     [NS][NW];
    logic [31:0] exp_mem [NS][NW];
    logic        fill_go = 1'b0;
    logic        poke_go = 1'b0;
    int          poke_set, poke_way;
    logic [31:0] poke_val;

    function automatic logic [31:0] rnd_entry();
        logic [31:0] e;
        e        = $urandom;
        e[14:1]  = 14'($urandom % 8);
        e[15]    = ($urandom % 4) != 0;
        return e;
    endfunction

    // tag store model, one-cycle read latency
    always @(posedge clk) begin
        if (fill_go) begin
            for (int s = 0; s < NS; s++)
                for (int w = 0; w < NW; w++) mem[s][w] <= rnd_entry();
        end else if (poke_go) begin
            mem[poke_set][poke_way] <= poke_val;
        end else begin
            for (int w = 0; w < NW; w++)
                if (tr_wr_en && tr_wr_mask[w]) mem[tr_wr_set][w] <= tr_wr_data[w*32 +: 32];
        end
        if (tr_rd_en)
            for (int w = 0; w < NW; w++) tr_rd_data[w*32 +: 32] <= mem[tr_rd_set][w];
    end

    // write-out agent with random acceptance delay
    logic [31:0] act_wb_addr [4096];
    logic [1:0]  act_wb_way  [4096];
    int          act_wb_n = 0;
    int          wr_total = 0;
    int          wb_delay = 0;
    int          wb_wait  = 0;

    always @(negedge clk) begin
        if (tr_wr_en) wr_total <= wr_total + 1;
        if (wb_ack) begin
            wb_ack  <= 1'b0;
            wb_wait <= 0;
        end else if (wb_req) begin
            if (wb_wait >= wb_delay) begin
                act_wb_addr[act_wb_n % 4096] <= wb_addr;
                act_wb_way[act_wb_n % 4096]  <= wb_way;
                act_wb_n <= act_wb_n + 1;
                wb_ack   <= 1'b1;
                wb_delay <= $urandom % 4;
            end else begin
                wb_wait <= wb_wait + 1;
            end
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    logic [31:0] exp_wb_addr [64];
    logic [1:0]  exp_wb_way  [64];
    int          exp_wb_n;

    function automatic string req_of(input int op);
        case (op)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3, 4: return "R7";
            5: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic model_apply(input int op, input logic [31:0] addr, input int lines);
        longint start, a, o;
        int set, tg, hw;
        exp_wb_n = 0;
        if (op == 5) begin
            for (int s = 0; s < NS; s++)
                for (int w = 0; w < NW; w++) exp_mem[s][w][15] = 1'b0;
            return;
        end
        if (op > 5) return;
        start = longint'(addr) & ~longint'(15);
        if (lines == 0 || start < longint'(BASE) ||
            start + longint'(lines) * 16 > longint'(BASE) + WINB) return;
        for (int i = 0; i < lines; i++) begin
            a   = start + longint'(i) * 16;
            o   = a - longint'(BASE);
            set = int'((o >> 4) & 127);
            tg  = int'((o >> 11) & 2047);
            hw  = -1;
            for (int w = NW - 1; w >= 0; w--)
                if (exp_mem[set][w][15] && exp_mem[set][w][14:1] == 14'(tg)) hw = w;
            if (hw >= 0) begin
                case (op)
                    0: exp_mem[set][hw][15] = 1'b0;
                    1: exp_mem[set][hw][0]  = 1'b0;
                    2: begin
                        if (exp_mem[set][hw][0]) begin
                            exp_wb_addr[exp_wb_n] = 32'(a);
                            exp_wb_way[exp_wb_n]  = 2'(hw);
                            exp_wb_n++;
                        end
                        exp_mem[set][hw][0] = 1'b0;
                    end
                    3: exp_mem[set][hw][19] = 1'b1;
                    default: exp_mem[set][hw][19] = 1'b0;
                endcase
            end
        end
    endtask

    task automatic compare_mem(input string rq);
        bit ok = 1'b1;
        int fs = 0, fw = 0;
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++)
                if (ok && mem[s][w] !== exp_mem[s][w]) begin
                    ok = 1'b0; fs = s; fw = w;
                end
        chk(ok, $sformatf("%s store set %0d way %0d got %h exp %h",
            rq, fs, fw, mem[fs][fw], exp_mem[fs][fw]));
    endtask

    task automatic run_cmd(input int op, input logic [31:0] addr, input int lines,
                           input string rq, input bit inject, input bit no_write);
        int wb0, wr0, n;
        model_apply(op, addr, lines);
        wb0 = act_wb_n;
        wr0 = wr_total;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = addr; cmd_lines = 16'(lines);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_busy === 1'b1, $sformatf("R2 busy after accept got %b exp 1", cmd_busy));
        if (inject) begin
            cmd_valid = 1'b1; cmd_op = 3'd3; cmd_addr = BASE; cmd_lines = 16'd64;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        n = 0;
        while (!cmd_done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 5000, $sformatf("%s command timeout got %0d cycles exp <5000", rq, n));
        chk(cmd_busy === 1'b1, $sformatf("R11 busy at done got %b exp 1", cmd_busy));
        @(negedge clk);
        chk(cmd_done === 1'b0 && cmd_busy === 1'b0,
            $sformatf("R11 after done got done=%b busy=%b exp 0 0", cmd_done, cmd_busy));
        compare_mem(rq);
        chk(act_wb_n - wb0 == exp_wb_n,
            $sformatf("R6 write-out count got %0d exp %0d", act_wb_n - wb0, exp_wb_n));
        if (act_wb_n - wb0 == exp_wb_n)
            for (int i = 0; i < exp_wb_n; i++)
                chk(act_wb_addr[(wb0 + i) % 4096] === exp_wb_addr[i] &&
                    act_wb_way[(wb0 + i) % 4096] === exp_wb_way[i],
                    $sformatf("R6 write-out %0d got %h/%0d exp %h/%0d", i,
                        act_wb_addr[(wb0 + i) % 4096], act_wb_way[(wb0 + i) % 4096],
                        exp_wb_addr[i], exp_wb_way[i]));
        if (no_write)
            chk(wr_total == wr0, $sformatf("%s store writes got %0d exp 0", rq, wr_total - wr0));
    endtask

    task automatic refill();
        @(negedge clk); fill_go = 1'b1;
        @(negedge clk); fill_go = 1'b0;
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) exp_mem[s][w] = mem[s][w];
    endtask

    task automatic poke(input int s, input int w, input logic [31:0] v);
        @(negedge clk);
        poke_set = s; poke_way = w; poke_val = v; poke_go = 1'b1;
        @(negedge clk); poke_go = 1'b0;
        exp_mem[s][w] = v;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int op, r, lines;
        logic [31:0] addr;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_lines = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_busy && !cmd_done && !tr_rd_en && !tr_wr_en && !wb_req,
            $sformatf("R1 reset outputs got busy=%b done=%b rd=%b wr=%b wb=%b exp all 0",
                cmd_busy, cmd_done, tr_rd_en, tr_wr_en, wb_req));

        refill();
        // R10 sweep with an arbitrary address
        run_cmd(5, 32'h0000_1234, 0, "R10", 1'b0, 1'b0);

        refill();
        // R3 duplicate tag in ways 1 and 3: lowest way only
        poke(5, 1, 32'hA5F0_8005);
        poke(5, 3, 32'h5A0F_8005);
        run_cmd(1, BASE + 32'd4096 + 32'd80, 1, "R3", 1'b0, 1'b0);
        run_cmd(1, BASE + 32'd40, 20, "R5", 1'b0, 1'b0);
        run_cmd(2, BASE + 32'd2048, 30, "R6", 1'b0, 1'b0);
        run_cmd(3, BASE + 32'd6000, 25, "R7", 1'b0, 1'b0);
        run_cmd(4, BASE + 32'd6016, 10, "R7", 1'b0, 1'b0);
        run_cmd(0, BASE + 32'd8192, 16, "R4", 1'b0, 1'b0);
        // R8 unaligned start
        run_cmd(0, BASE + 32'h1237, 3, "R8", 1'b0, 1'b0);
        // R9 rejections
        run_cmd(0, BASE - 32'd16, 4, "R9", 1'b0, 1'b1);
        run_cmd(3, BASE + 32'h003F_FFE0, 3, "R9", 1'b0, 1'b1);
        run_cmd(0, BASE + 32'd64, 0, "R9", 1'b0, 1'b1);
        run_cmd(3, BASE + 32'h003F_FFE0, 2, "R9", 1'b0, 1'b0);
        // R12 reserved codes
        run_cmd(6, BASE, 8, "R12", 1'b0, 1'b1);
        run_cmd(7, BASE, 8, "R12", 1'b0, 1'b1);
        // R2 command while busy is ignored
        run_cmd(1, BASE + 32'd256, 20, "R2", 1'b1, 1'b0);

        for (int i = 0; i < 30; i++) begin
            r = int'($urandom % 10);
            if (r < 8) op = r % 5;
            else if (r == 8) op = 5;
            else op = 6 + int'($urandom % 2);
            addr  = BASE + ($urandom % 16384);
            lines = 1 + int'($urandom % 40);
            run_cmd(op, addr, lines, req_of(op), 1'b0, op > 5);
            if (op == 5) refill();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule